// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave

This block is a synthesizable behavioural model of a small serial EEPROM that answers a three-wire command stream: chip select, serial clock and serial data in, plus a data output with a separate enable so the pad can be tri-stated. All inputs are sampled by the system clock. Rising edges of the serial clock are found inside the block. Each instruction opens with a start bit of 1. Next come a two-bit opcode and an address field, and then a data field for writes. The stored words live in a byte-organised register array.

A static organisation input picks one of two word sizes. In x16 mode the array is seen as 16-bit words with a 6-bit address. In x8 mode it is seen as bytes with a 7-bit address. Opcode 00 carries four system commands, and the two top address bits select which one. Programming commands take effect when chip select falls after a complete instruction. A parameterised busy counter then models the programming time. While that counter runs, the data line reports busy or ready whenever chip select is high.

Top module: `eep_uwire_slave`

## Requirements
- R1: After reset every location reads all ones, writes are locked, and `sdo_oe` is low.
- R2: Zero bits clocked in while selected and idle are skipped. An instruction starts at the first 1 sampled on a serial clock rise.
- R3: READ (opcode 10) in x16 mode: from the rise that samples the last of the 6 address bits, `sdo_oe` is high and `sdo` carries bit 15 of the word. Each later rise presents the next lower bit, down to bit 0.
- R4: READ in x8 mode uses a 7-bit address and shifts out an 8-bit byte, most significant bit first.
- R5: Writes are locked after reset and after the lock command (opcode 00, top address bits 00). While locked, ERASE, WRITE, ERASE-ALL and WRITE-ALL change nothing and raise no status.
- R6: The unlock command is opcode 00 with top address bits 11. WRITE (opcode 01) then stores its data word when chip select falls. x16 word k occupies byte 2k+1 (high half) and byte 2k (low half) of the x8 view.
- R7: ERASE (opcode 11) sets every bit of the addressed word to 1.
- R8: ERASE-ALL (opcode 00, top bits 10) sets all locations to ones. WRITE-ALL (opcode 00, top bits 01) stores its data word in every location.
- R9: After an accepted programming command, `sdo_oe` is high whenever chip select is high and no instruction is running. `sdo` is 0 for exactly `BUSY_CYCLES` clock cycles counted from the clock edge that sees chip select low, and 1 after that. Start bits sent while busy are ignored.
- R10: `sdo_oe` is low while chip select is low, while the header is being received, and throughout the unlock and lock commands.
- R11: An instruction cut short by chip select falling before its last bit has no effect on memory and raises no status.
- R12: The status display ends when a start bit is accepted after ready. `sdo_oe` goes low from that bit on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| org_x16 | input | 1 | Word organisation: 1 selects 16-bit words, 0 selects bytes |
| cs | input | 1 | Chip select, active high |
| sclk | input | 1 | Serial clock; bits are taken on its rising edge |
| sdi | input | 1 | Serial command, address and data input |
| sdo | output | 1 | Serial read data, or the busy (0) / ready (1) status |
| sdo_oe | output | 1 | Output enable for `sdo`; low means high impedance |

## Verification
The hardest situation to reach is a start bit arriving while the busy counter is still running. It needs an unlocked programming command, a deselect that commits it, and a reselect inside the busy window. The stimulus does exactly that after an ERASE. It sends a start bit a few cycles into the window and checks that the busy status is still shown. It then waits past the window, checks for ready, and sends a second start bit to show that the display ends. The busy window is also measured to the exact cycle against `BUSY_CYCLES`.

// File: rtl/eep_pkg.sv
package eep_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_HDR,
      ST_DATA,
      ST_RDOUT,
      ST_DONE
   } eep_state_e;

   typedef enum logic [2:0] {
      CMD_NONE,
      CMD_READ,
      CMD_WRITE,
      CMD_ERASE,
      CMD_ERAL,
      CMD_WRAL,
      CMD_EWEN,
      CMD_EWDS
   } eep_cmd_e;

   localparam logic [1:0] OPC_SYS   = 2'b00;
   localparam logic [1:0] OPC_WRITE = 2'b01;
   localparam logic [1:0] OPC_READ  = 2'b10;
   localparam logic [1:0] OPC_ERASE = 2'b11;

   localparam logic [1:0] SYS_LOCK   = 2'b00;
   localparam logic [1:0] SYS_FILL   = 2'b01;
   localparam logic [1:0] SYS_WIPE   = 2'b10;
   localparam logic [1:0] SYS_UNLOCK = 2'b11;

   function automatic eep_cmd_e decode_cmd(input logic [1:0] op, input logic [1:0] sel);
      eep_cmd_e c;
      case (op)
         OPC_READ:  c = CMD_READ;
         OPC_WRITE: c = CMD_WRITE;
         OPC_ERASE: c = CMD_ERASE;
         default: begin
            case (sel)
               SYS_UNLOCK: c = CMD_EWEN;
               SYS_LOCK:   c = CMD_EWDS;
               SYS_WIPE:   c = CMD_ERAL;
               default:    c = CMD_WRAL;
            endcase
         end
      endcase
      return c;
   endfunction

   function automatic logic is_prog(input eep_cmd_e c);
      return (c == CMD_ERASE) || (c == CMD_ERAL) || (c == CMD_WRITE) || (c == CMD_WRAL);
   endfunction

endpackage

// File: rtl/eep_edge.sv
module eep_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic sclk,
   input  logic cs,
   output logic sclk_rise,
   output logic cs_fall
);
   logic sclk_q, cs_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sclk_q <= 1'b0;
         cs_q   <= 1'b0;
      end else begin
         sclk_q <= sclk;
         cs_q   <= cs;
      end
   end

   assign sclk_rise = sclk & ~sclk_q;
   assign cs_fall   = ~cs & cs_q;
endmodule

// File: rtl/eep_frame.sv
module eep_frame
   import eep_pkg::*;
#(
   parameter int ADDR8_W = 7
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               org_x16,
   input  logic               cs,
   input  logic               sclk_rise,
   input  logic               sdi,
   input  logic               busy,
   output eep_state_e         state_q,
   output eep_cmd_e           cmd_q,
   output logic [ADDR8_W-1:0] addr_q,
   output logic [15:0]        wdata_q,
   output logic               start_ok,
   output logic               rd_load,
   output logic [ADDR8_W-1:0] rd_addr
);
   localparam int HDR_W = 2 + ADDR8_W;
   localparam int CNT_W = $clog2(HDR_W + 17);

   logic [HDR_W-1:0]   hdr_q, hdr_n;
   logic [CNT_W-1:0]   cnt_q, hdr_last, data_last;
   logic [1:0]         op_n, top2_n;
   logic [ADDR8_W-1:0] addr_n;
   eep_cmd_e           cmd_n;
   logic               step, hdr_done;

   assign hdr_n     = {hdr_q[HDR_W-2:0], sdi};
   assign hdr_last  = org_x16 ? CNT_W'(HDR_W - 2) : CNT_W'(HDR_W - 1);
   assign data_last = org_x16 ? CNT_W'(15) : CNT_W'(7);
   assign op_n      = org_x16 ? hdr_n[HDR_W-2 -: 2] : hdr_n[HDR_W-1 -: 2];
   assign addr_n    = org_x16 ? {1'b0, hdr_n[ADDR8_W-2:0]} : hdr_n[ADDR8_W-1:0];
   assign top2_n    = org_x16 ? addr_n[ADDR8_W-2 -: 2] : addr_n[ADDR8_W-1 -: 2];
   assign cmd_n     = decode_cmd(op_n, top2_n);

   assign step     = sclk_rise & cs;
   assign hdr_done = step && (state_q == ST_HDR) && (cnt_q == hdr_last);
   assign start_ok = step && (state_q == ST_IDLE) && sdi && !busy;
   assign rd_load  = hdr_done && (cmd_n == CMD_READ);
   assign rd_addr  = addr_n;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cmd_q   <= CMD_NONE;
         cnt_q   <= '0;
         hdr_q   <= '0;
         addr_q  <= '0;
         wdata_q <= '0;
      end else if (!cs) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
      end else if (step) begin
         case (state_q)
            ST_IDLE: begin
               if (start_ok) begin
                  state_q <= ST_HDR;
                  cnt_q   <= '0;
                  hdr_q   <= '0;
               end
            end
            ST_HDR: begin
               hdr_q <= hdr_n;
               cnt_q <= cnt_q + CNT_W'(1);
               if (hdr_done) begin
                  cmd_q   <= cmd_n;
                  addr_q  <= addr_n;
                  cnt_q   <= '0;
                  wdata_q <= '0;
                  case (cmd_n)
                     CMD_READ:           state_q <= ST_RDOUT;
                     CMD_WRITE, CMD_WRAL: state_q <= ST_DATA;
                     default:            state_q <= ST_DONE;
                  endcase
               end
            end
            ST_DATA: begin
               wdata_q <= {wdata_q[14:0], sdi};
               cnt_q   <= cnt_q + CNT_W'(1);
               if (cnt_q == data_last) state_q <= ST_DONE;
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/eep_array.sv
module eep_array #(
   parameter int ADDR8_W = 7
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               we,
   input  logic               all,
   input  logic               x16,
   input  logic [ADDR8_W-1:0] addr,
   input  logic [15:0]        wdata,
   input  logic [ADDR8_W-1:0] raddr,
   output logic [15:0]        rword
);
   localparam int NBYTES = 1 << ADDR8_W;

   logic [7:0] cells [NBYTES];

   for (genvar i = 0; i < NBYTES; i++) begin : g_cell
      localparam logic [ADDR8_W-1:0] IDX = ADDR8_W'(i);
      logic       hit;
      logic [7:0] bval;
      logic [7:0] cell_q;

      assign hit  = x16 ? (addr[ADDR8_W-2:0] == IDX[ADDR8_W-1:1]) : (addr == IDX);
      assign bval = (x16 && IDX[0]) ? wdata[15:8] : wdata[7:0];

      always_ff @(posedge clk) begin
         if (!rst_n)              cell_q <= 8'hFF;
         else if (we && (all || hit)) cell_q <= bval;
      end

      assign cells[i] = cell_q;
   end

   assign rword = x16 ? {cells[{raddr[ADDR8_W-2:0], 1'b1}], cells[{raddr[ADDR8_W-2:0], 1'b0}]}
                      : {8'h00, cells[raddr]};
endmodule

// File: rtl/eep_busy.sv
module eep_busy #(
   parameter int BUSY_CYCLES = 400
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   output logic busy
);
   if (BUSY_CYCLES == 0) begin : g_instant
      assign busy = 1'b0;
   end else begin : g_count
      localparam int CW = $clog2(BUSY_CYCLES + 1);
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk) begin
         if (!rst_n)             cnt_q <= '0;
         else if (load)          cnt_q <= CW'(BUSY_CYCLES);
         else if (cnt_q != '0)   cnt_q <= cnt_q - CW'(1);
      end

      assign busy = (cnt_q != '0);
   end
endmodule

// File: rtl/eep_uwire_slave.sv
module eep_uwire_slave
   import eep_pkg::*;
#(
   parameter int ADDR8_W     = 7,
   parameter int BUSY_CYCLES = 400
) (
   input  logic clk,
   input  logic rst_n,
   input  logic org_x16,
   input  logic cs,
   input  logic sclk,
   input  logic sdi,
   output logic sdo,
   output logic sdo_oe
);
   if (ADDR8_W < 3 || ADDR8_W > 10) begin : g_bad_addr
      $error("eep_uwire_slave: ADDR8_W must lie in 3..10");
   end
   if (BUSY_CYCLES < 0) begin : g_bad_busy
      $error("eep_uwire_slave: BUSY_CYCLES must not be negative");
   end

   logic               sclk_rise, cs_fall, busy, start_ok, rd_load;
   logic               commit, mem_we, mem_all, wen_q, status_q;
   eep_state_e         state_q;
   eep_cmd_e           cmd_q;
   logic [ADDR8_W-1:0] addr_q, rd_addr;
   logic [15:0]        wdata_q, mem_data, rword, rd_sh;

   eep_edge u_edge (
      .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs(cs),
      .sclk_rise(sclk_rise), .cs_fall(cs_fall)
   );

   eep_frame #(.ADDR8_W(ADDR8_W)) u_frame (
      .clk(clk), .rst_n(rst_n), .org_x16(org_x16), .cs(cs),
      .sclk_rise(sclk_rise), .sdi(sdi), .busy(busy),
      .state_q(state_q), .cmd_q(cmd_q), .addr_q(addr_q), .wdata_q(wdata_q),
      .start_ok(start_ok), .rd_load(rd_load), .rd_addr(rd_addr)
   );

   assign commit   = cs_fall && (state_q == ST_DONE);
   assign mem_we   = commit && is_prog(cmd_q) && wen_q;
   assign mem_all  = (cmd_q == CMD_ERAL) || (cmd_q == CMD_WRAL);
   assign mem_data = ((cmd_q == CMD_WRITE) || (cmd_q == CMD_WRAL)) ? wdata_q : 16'hFFFF;

   eep_array #(.ADDR8_W(ADDR8_W)) u_array (
      .clk(clk), .rst_n(rst_n), .we(mem_we), .all(mem_all), .x16(org_x16),
      .addr(addr_q), .wdata(mem_data), .raddr(rd_addr), .rword(rword)
   );

   eep_busy #(.BUSY_CYCLES(BUSY_CYCLES)) u_busy (
      .clk(clk), .rst_n(rst_n), .load(mem_we), .busy(busy)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wen_q    <= 1'b0;
         status_q <= 1'b0;
         rd_sh    <= '0;
      end else begin
         if (commit && cmd_q == CMD_EWEN)      wen_q <= 1'b1;
         else if (commit && cmd_q == CMD_EWDS) wen_q <= 1'b0;

         if (mem_we)        status_q <= 1'b1;
         else if (start_ok) status_q <= 1'b0;

         if (rd_load)
            rd_sh <= org_x16 ? rword : {rword[7:0], 8'h00};
         else if (sclk_rise && cs && state_q == ST_RDOUT)
            rd_sh <= {rd_sh[14:0], 1'b0};
      end
   end

   assign sdo_oe = cs && ((state_q == ST_RDOUT) || (state_q == ST_IDLE && status_q));
   assign sdo    = (state_q == ST_RDOUT) ? rd_sh[15] : !busy;
endmodule

// File: rtl/eep_uwire_chk.sv
module eep_uwire_chk #(
   parameter int BUSY_CYCLES = 400
) (
   input logic clk,
   input logic rst_n,
   input logic cs,
   input logic sdo,
   input logic sdo_oe,
   input logic mem_we,
   input logic wen_q,
   input logic busy,
   input logic status_q
);
   a_r5_write_needs_unlock: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> wen_q);

   a_r11_commit_on_deselect: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (!cs && $past(cs)));

   a_r10_hiz_deselected: assert property (@(posedge clk) disable iff (!rst_n)
      !cs |-> !sdo_oe);

   a_r9_busy_after_commit: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> (busy || BUSY_CYCLES == 0));

   a_r9_busy_drives_low: assert property (@(posedge clk) disable iff (!rst_n)
      (sdo_oe && status_q && busy) |-> !sdo);
endmodule

bind eep_uwire_slave eep_uwire_chk #(.BUSY_CYCLES(BUSY_CYCLES)) u_chk (
   .clk(clk), .rst_n(rst_n), .cs(cs), .sdo(sdo), .sdo_oe(sdo_oe),
   .mem_we(mem_we), .wen_q(wen_q), .busy(busy), .status_q(status_q)
);

// File: tb/sim_eep_uwire_slave.sv
`timescale 1ns/1ps
module sim_eep_uwire_slave;
   localparam int NBUSY = 40;

   logic clk = 1'b0;
   logic rst_n, org_x16, cs, sclk, sdi;
   logic sdo, sdo_oe;
   int   n_vec = 0;
   int   n_bad = 0;

   always #2.5 clk = ~clk;

   eep_uwire_slave #(.ADDR8_W(7), .BUSY_CYCLES(NBUSY)) u0 (
      .clk(clk), .rst_n(rst_n), .org_x16(org_x16), .cs(cs),
      .sclk(sclk), .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic send_bit(input logic b);
      @(negedge clk); sdi = b; sclk = 1'b1;
      @(negedge clk); sclk = 1'b0;
   endtask

   task automatic select();
      @(negedge clk); cs = 1'b1;
   endtask

   task automatic deselect();
      @(negedge clk); cs = 1'b0;
      @(negedge clk);
   endtask

   function automatic logic [6:0] sys_addr(input logic x16, input logic [1:0] code);
      return x16 ? {1'b0, code, 4'b0} : {code, 5'b0};
   endfunction

   task automatic send_hdr(input logic x16, input logic [1:0] op, input logic [6:0] a);
      send_bit(1'b1);
      send_bit(op[1]); send_bit(op[0]);
      for (int i = (x16 ? 5 : 6); i >= 0; i--) send_bit(a[i]);
   endtask

   task automatic run_cmd(input logic x16, input logic [1:0] op, input logic [6:0] a,
                          input logic [15:0] d, input int nd);
      org_x16 = x16;
      select();
      send_hdr(x16, op, a);
      for (int i = nd - 1; i >= 0; i--) send_bit(d[i]);
      deselect();
   endtask

   task automatic read_word(input logic x16, input logic [6:0] a, output logic [15:0] w);
      org_x16 = x16;
      select();
      send_hdr(x16, 2'b10, a);
      w = '0;
      w = {w[14:0], sdo};
      for (int k = 1; k < (x16 ? 16 : 8); k++) begin
         send_bit(1'b0);
         w = {w[14:0], sdo};
      end
      deselect();
   endtask

   // Called right after a committing deselect: the busy window is measured exactly.
   task automatic wait_ready(input string req);
      cs = 1'b1;
      repeat (NBUSY - 1) @(negedge clk);
      check({req, " busy last cycle"}, {30'd0, sdo_oe, sdo}, 32'd2);
      @(negedge clk);
      check({req, " ready"}, {30'd0, sdo_oe, sdo}, 32'd3);
      cs = 1'b0;
   endtask

   task automatic t_reset();
      logic [15:0] w;
      check("R1 oe after reset", {31'd0, sdo_oe}, 32'd0);
      read_word(1'b1, 7'd0, w);
      check("R1 erased word 0", {16'd0, w}, 32'h0000FFFF);
   endtask

   task automatic t_locked_write();
      logic [15:0] w;
      run_cmd(1'b1, 2'b01, 7'd3, 16'h1234, 16);
      cs = 1'b1;
      @(negedge clk);
      check("R5 no status when locked", {31'd0, sdo_oe}, 32'd0);
      cs = 1'b0;
      read_word(1'b1, 7'd3, w);
      check("R5 locked write ignored", {16'd0, w}, 32'h0000FFFF);
   endtask

   task automatic t_unlock_write();
      logic [15:0] w;
      org_x16 = 1'b1;
      select();
      send_hdr(1'b1, 2'b00, sys_addr(1'b1, 2'b11));
      check("R10 oe low during unlock", {31'd0, sdo_oe}, 32'd0);
      deselect();
      run_cmd(1'b1, 2'b01, 7'd5, 16'hA5C3, 16);
      wait_ready("R9 write");
      read_word(1'b1, 7'd5, w);
      check("R3 R6 x16 readback", {16'd0, w}, 32'h0000A5C3);
      read_word(1'b0, 7'd10, w);
      check("R4 R6 low byte at 2k", {16'd0, w}, 32'h000000C3);
      read_word(1'b0, 7'd11, w);
      check("R4 R6 high byte at 2k+1", {16'd0, w}, 32'h000000A5);
   endtask

   task automatic t_leading_zeros();
      logic [15:0] w;
      org_x16 = 1'b1;
      select();
      send_bit(1'b0); send_bit(1'b0); send_bit(1'b0);
      check("R2 zeros ignored", {31'd0, sdo_oe}, 32'd0);
      send_hdr(1'b1, 2'b10, 7'd5);
      check("R3 oe on after header", {31'd0, sdo_oe}, 32'd1);
      w = '0;
      w = {w[14:0], sdo};
      for (int k = 1; k < 16; k++) begin
         send_bit(1'b1);
         w = {w[14:0], sdo};
      end
      deselect();
      check("R2 read after leading zeros", {16'd0, w}, 32'h0000A5C3);
   endtask

   task automatic t_x8_write();
      logic [15:0] w;
      run_cmd(1'b0, 2'b01, 7'h7F, 16'h005A, 8);
      wait_ready("R9 x8 write");
      read_word(1'b0, 7'h7F, w);
      check("R4 x8 write readback", {16'd0, w}, 32'h0000005A);
   endtask

   task automatic t_erase_busy_start();
      logic [15:0] w;
      run_cmd(1'b1, 2'b11, 7'd5, 16'h0, 0);
      cs = 1'b1;
      send_bit(1'b1);
      check("R9 start ignored while busy", {30'd0, sdo_oe, sdo}, 32'd2);
      repeat (NBUSY) @(negedge clk);
      check("R9 still status then ready", {30'd0, sdo_oe, sdo}, 32'd3);
      send_bit(1'b1);
      check("R12 start ends status", {31'd0, sdo_oe}, 32'd0);
      cs = 1'b0;
      @(negedge clk);
      read_word(1'b1, 7'd5, w);
      check("R7 erased word", {16'd0, w}, 32'h0000FFFF);
   endtask

   task automatic t_abort();
      logic [15:0] w;
      org_x16 = 1'b1;
      select();
      send_hdr(1'b1, 2'b01, 7'd2);
      for (int i = 0; i < 10; i++) send_bit(1'b0);
      deselect();
      cs = 1'b1;
      @(negedge clk);
      check("R11 no status after abort", {31'd0, sdo_oe}, 32'd0);
      cs = 1'b0;
      read_word(1'b1, 7'd2, w);
      check("R11 aborted write no effect", {16'd0, w}, 32'h0000FFFF);
   endtask

   task automatic t_fill_wipe();
      logic [15:0] w;
      run_cmd(1'b1, 2'b00, sys_addr(1'b1, 2'b01), 16'h0F3C, 16);
      wait_ready("R9 fill");
      read_word(1'b1, 7'd63, w);
      check("R8 write-all word 63", {16'd0, w}, 32'h00000F3C);
      read_word(1'b0, 7'd1, w);
      check("R8 write-all byte 1", {16'd0, w}, 32'h0000000F);
      run_cmd(1'b0, 2'b00, sys_addr(1'b0, 2'b10), 16'h0, 0);
      wait_ready("R9 wipe");
      read_word(1'b1, 7'd7, w);
      check("R8 erase-all word 7", {16'd0, w}, 32'h0000FFFF);
   endtask

   task automatic t_relock();
      logic [15:0] w;
      org_x16 = 1'b1;
      select();
      send_hdr(1'b1, 2'b00, sys_addr(1'b1, 2'b00));
      check("R10 oe low during lock", {31'd0, sdo_oe}, 32'd0);
      deselect();
      run_cmd(1'b1, 2'b01, 7'd9, 16'h0000, 16);
      run_cmd(1'b1, 2'b00, sys_addr(1'b1, 2'b10), 16'h0, 0);
      read_word(1'b1, 7'd9, w);
      check("R5 write after lock ignored", {16'd0, w}, 32'h0000FFFF);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      rst_n = 1'b0; org_x16 = 1'b1; cs = 1'b0; sclk = 1'b0; sdi = 1'b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_locked_write();
      t_unlock_write();
      t_leading_zeros();
      t_x8_write();
      t_erase_busy_start();
      t_abort();
      t_fill_wipe();
      t_relock();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule